// File: doc/BRIEF.md
# Quadrant Tree Lossless Encoder

This block losslessly packs one square tile of small quantizer codes into a tree-shaped bitstream. The codes are the residuals a predictive coder and an adaptive quantizer produce upstream. A tile is accepted pixel by pixel in raster order, with a start marker on its first pixel. Each pixel is written into an internal buffer at its Z-order address, which interleaves the row and column bits so that every quadrant, at every level, fills a contiguous address range. Once the tile is complete, a pipelined tree of minimum and maximum registers settles in one cycle per level. A node is uniform exactly when its minimum equals its maximum.

A walker then visits the tree from the root, depth first, in Z order. A uniform quadrant is sent once, as a set flag followed by its single code. A mixed quadrant sends a clear flag and then its four children. A lone pixel sends only its code. The output is one token per handshake. The walker holds its position whenever the sink stalls. The final token of the tile carries a last marker, and the input stays closed until that token has left.

Top module: `qt_encoder`

## Requirements
- R1: While reset is asserted, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: A pixel accepted without `in_sof_i` while no tile has been started is discarded and has no effect on the next tile's output.
- R3: A pixel with `in_sof_i` set always becomes pixel 0 of a fresh tile, even in the middle of a partly loaded tile; the partial tile is dropped.
- R4: `in_ready_o` is 0 from the cycle after the tile's 64th pixel is accepted until the tile's last token has been transferred, and it is 1 again afterwards.
- R5: A tile whose 64 codes are all equal produces exactly two tokens: a flag token with value 1, then a value token carrying the code.
- R6: A non-uniform node emits a flag token with value 0, followed by the streams of its four children in the order top-left, top-right, bottom-left, bottom-right. Z address bit 2k is column bit k and bit 2k+1 is row bit k.
- R7: A single pixel inside a split 2x2 node emits only a value token, with no flag.
- R8: A uniform node below the root emits a flag token with value 1, then its code, and none of its pixels. The token after a set flag is always a value token.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, the output token (data, flag, last) holds stable and no token is lost.
- R10: `out_last_o` is 1 on exactly the final token of each tile, which is always a value token, and `out_valid_o` drops in the cycle after it is transferred.
- R11: Token format: `out_flag_o`=1 marks a flag token whose bit is `out_data_o[0]`, with the upper data bits 0; `out_flag_o`=0 marks a value token whose `out_data_o` is a 3-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Encoder can accept a pixel |
| in_sof_i | input | 1 | Pixel is the first of a tile |
| in_code_i | input | CODE_W (3) | Quantizer code, raster order |
| out_valid_o | output | 1 | Output token valid |
| out_ready_i | input | 1 | Sink accepts the token |
| out_flag_o | output | 1 | Token is a split/uniform flag |
| out_data_o | output | CODE_W (3) | Flag bit in bit 0, or code value |
| out_last_o | output | 1 | Final token of the tile |

## Verification
The case that is hardest to reach is a mixed tree: uniform quadrants at different depths next to split 2x2 nodes. Only that combination exercises the walker's climb after a finished subtree, where it must rise several levels at once and skip pixels it never emits. Reaching it needs tiles crafted in raster order that map to uniform 4x4 and 2x2 Z-order blocks beside fully distinct pixels. The bench drives these tiles while the sink randomly drops ready, so that stalls land on flag tokens, value tokens and the last token alike. Discard and restart of a partial tile are also driven just before such a tile.

// File: rtl/qt_pkg.sv
package qt_pkg;
  localparam int unsigned LVLS_DEF   = 3;
  localparam int unsigned CODE_W_DEF = 3;

  typedef enum logic [1:0] {
    ST_LOAD,
    ST_SETTLE,
    ST_EMIT
  } enc_state_e;

  // first index of tree level l in a flat node array (level 0 = pixels)
  function automatic int unsigned node_base(int unsigned lvls, int unsigned l);
    int unsigned b;
    b = 0;
    for (int unsigned j = 0; j < l; j++) b += (1 << (2 * (lvls - j)));
    return b;
  endfunction
endpackage

// File: rtl/qt_morton.sv
module qt_morton #(
  parameter int unsigned LVLS = qt_pkg::LVLS_DEF,
  localparam int unsigned PW  = 2 * LVLS
) (
  input  logic [LVLS-1:0] row_i,
  input  logic [LVLS-1:0] col_i,
  output logic [PW-1:0]   addr_o
);
  for (genvar b = 0; b < LVLS; b++) begin : g_bit
    assign addr_o[2*b]   = col_i[b];
    assign addr_o[2*b+1] = row_i[b];
  end
endmodule

// File: rtl/qt_tile_buf.sv
module qt_tile_buf #(
  parameter int unsigned LVLS   = qt_pkg::LVLS_DEF,
  parameter int unsigned CODE_W = qt_pkg::CODE_W_DEF,
  localparam int unsigned PW    = 2 * LVLS,
  localparam int unsigned LW    = $clog2(LVLS + 1),
  localparam int unsigned NPIX  = 1 << PW,
  localparam int unsigned NTOT  = qt_pkg::node_base(LVLS, LVLS + 1),
  localparam int unsigned IW    = $clog2(NTOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PW-1:0]     wr_addr_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic [LW-1:0]     rd_lvl_i,
  input  logic [PW-1:0]     rd_pos_i,
  output logic              rd_uni_o,
  output logic [CODE_W-1:0] rd_val_o
);
  logic [CODE_W-1:0] mn_q [NTOT];
  logic [CODE_W-1:0] mx_q [NTOT];
  logic [IW-1:0]     rd_idx;

  function automatic logic [CODE_W-1:0] lo2(logic [CODE_W-1:0] a, logic [CODE_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
  function automatic logic [CODE_W-1:0] hi2(logic [CODE_W-1:0] a, logic [CODE_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // pixels live in entries [0, NPIX); each level above is one register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NTOT; i++) begin
        mn_q[i] <= '0;
        mx_q[i] <= '0;
      end
    end else begin
      if (wr_en_i) begin
        mn_q[wr_addr_i] <= wr_code_i;
        mx_q[wr_addr_i] <= wr_code_i;
      end
      for (int l = 1; l <= LVLS; l++) begin
        for (int n = 0; n < (NPIX >> (2 * l)); n++) begin
          mn_q[IW'(qt_pkg::node_base(LVLS, l) + n)] <=
            lo2(lo2(mn_q[IW'(qt_pkg::node_base(LVLS, l-1) + 4*n)],
                    mn_q[IW'(qt_pkg::node_base(LVLS, l-1) + 4*n + 1)]),
                lo2(mn_q[IW'(qt_pkg::node_base(LVLS, l-1) + 4*n + 2)],
                    mn_q[IW'(qt_pkg::node_base(LVLS, l-1) + 4*n + 3)]));
          mx_q[IW'(qt_pkg::node_base(LVLS, l) + n)] <=
            hi2(hi2(mx_q[IW'(qt_pkg::node_base(LVLS, l-1) + 4*n)],
                    mx_q[IW'(qt_pkg::node_base(LVLS, l-1) + 4*n + 1)]),
                hi2(mx_q[IW'(qt_pkg::node_base(LVLS, l-1) + 4*n + 2)],
                    mx_q[IW'(qt_pkg::node_base(LVLS, l-1) + 4*n + 3)]));
        end
      end
    end
  end

  always_comb begin
    rd_idx   = IW'(qt_pkg::node_base(LVLS, int'(rd_lvl_i))) + IW'(rd_pos_i >> (2 * rd_lvl_i));
    rd_uni_o = (mn_q[rd_idx] == mx_q[rd_idx]);
    rd_val_o = mn_q[rd_idx];
  end
endmodule

// File: rtl/qt_walker.sv
module qt_walker #(
  parameter int unsigned LVLS   = qt_pkg::LVLS_DEF,
  parameter int unsigned CODE_W = qt_pkg::CODE_W_DEF,
  localparam int unsigned PW    = 2 * LVLS,
  localparam int unsigned LW    = $clog2(LVLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              uni_i,
  input  logic [CODE_W-1:0] val_i,
  output logic [LW-1:0]     lvl_o,
  output logic [PW-1:0]     pos_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              flag_o,
  output logic [CODE_W-1:0] data_o,
  output logic              last_o,
  output logic              done_o
);
  logic          busy_q, ph_q;
  logic [PW-1:0] pos_q;
  logic [LW-1:0] lvl_q, nl;
  logic [PW:0]   nxt;
  logic          val_tok, wrap, fire;

  assign val_tok = (lvl_q == '0) || ph_q;  // token closes the current node
  assign nxt     = {1'b0, pos_q} + ((PW+1)'(1) << (2 * lvl_q));
  assign wrap    = nxt[PW];
  assign fire    = busy_q && ready_i;

  // climb while the next position starts a larger block
  always_comb begin
    nl = lvl_q;
    for (int l = 0; l < LVLS; l++)
      if (nl == LW'(l) && (nxt[PW-1:0] & PW'((1 << (2 * (l + 1))) - 1)) == '0)
        nl = LW'(l + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      pos_q  <= '0;
      lvl_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ph_q   <= 1'b0;
      pos_q  <= '0;
      lvl_q  <= LW'(LVLS);
    end else if (fire) begin
      if (val_tok) begin
        ph_q <= 1'b0;
        if (wrap) busy_q <= 1'b0;
        else begin
          pos_q <= nxt[PW-1:0];
          lvl_q <= nl;
        end
      end else if (uni_i) begin
        ph_q <= 1'b1;
      end else begin
        lvl_q <= lvl_q - LW'(1);
      end
    end
  end

  assign lvl_o   = lvl_q;
  assign pos_o   = pos_q;
  assign valid_o = busy_q;
  assign flag_o  = !val_tok;
  assign data_o  = val_tok ? val_i : {{(CODE_W-1){1'b0}}, uni_i};
  assign last_o  = busy_q && val_tok && wrap;
  assign done_o  = fire && val_tok && wrap;
endmodule

// File: rtl/qt_encoder.sv
module qt_encoder #(
  parameter int unsigned LVLS   = qt_pkg::LVLS_DEF,
  parameter int unsigned CODE_W = qt_pkg::CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_sof_i,
  input  logic [CODE_W-1:0] in_code_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_flag_o,
  output logic [CODE_W-1:0] out_data_o,
  output logic              out_last_o
);
  import qt_pkg::*;

  localparam int unsigned PW   = 2 * LVLS;
  localparam int unsigned LW   = $clog2(LVLS + 1);
  localparam int unsigned NPIX = 1 << PW;

  enc_state_e        state_q;
  logic [PW-1:0]     cnt_q, wr_idx, wr_addr;
  logic              filling_q, accept, wr_en, start;
  logic [LW-1:0]     settle_q, rd_lvl;
  logic [PW-1:0]     rd_pos;
  logic              rd_uni, walk_done;
  logic [CODE_W-1:0] rd_val;

  assign in_ready_o = (state_q == ST_LOAD);
  assign accept     = in_valid_i && in_ready_o;
  assign wr_en      = accept && (in_sof_i || filling_q);
  assign wr_idx     = in_sof_i ? '0 : cnt_q;
  assign start      = (state_q == ST_SETTLE) && (settle_q == LW'(LVLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_LOAD;
      cnt_q     <= '0;
      filling_q <= 1'b0;
      settle_q  <= '0;
    end else begin
      case (state_q)
        ST_LOAD: if (wr_en) begin
          if (wr_idx == PW'(NPIX - 1)) begin
            state_q   <= ST_SETTLE;
            filling_q <= 1'b0;
            cnt_q     <= '0;
            settle_q  <= '0;
          end else begin
            filling_q <= 1'b1;
            cnt_q     <= wr_idx + PW'(1);
          end
        end
        ST_SETTLE: begin
          settle_q <= settle_q + LW'(1);
          if (start) state_q <= ST_EMIT;
        end
        ST_EMIT: if (walk_done) state_q <= ST_LOAD;
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  qt_morton #(.LVLS(LVLS)) u_morton (
    .row_i  (wr_idx[PW-1:LVLS]),
    .col_i  (wr_idx[LVLS-1:0]),
    .addr_o (wr_addr)
  );

  qt_tile_buf #(.LVLS(LVLS), .CODE_W(CODE_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_code_i (in_code_i),
    .rd_lvl_i  (rd_lvl),
    .rd_pos_i  (rd_pos),
    .rd_uni_o  (rd_uni),
    .rd_val_o  (rd_val)
  );

  qt_walker #(.LVLS(LVLS), .CODE_W(CODE_W)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .uni_i   (rd_uni),
    .val_i   (rd_val),
    .lvl_o   (rd_lvl),
    .pos_o   (rd_pos),
    .valid_o (out_valid_o),
    .ready_i (out_ready_i),
    .flag_o  (out_flag_o),
    .data_o  (out_data_o),
    .last_o  (out_last_o),
    .done_o  (walk_done)
  );
endmodule

// File: rtl/qt_encoder_chk.sv
module qt_encoder_chk #(
  parameter int unsigned CODE_W = qt_pkg::CODE_W_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_flag_o,
  input logic [CODE_W-1:0] out_data_o,
  input logic              out_last_o
);
  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!out_valid_o && in_ready_o);
    end
  end

  p_input_closed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  p_hold_on_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_flag_o) && $stable(out_last_o)));

  p_flag_format_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_flag_o) |-> (out_data_o[CODE_W-1:1] == '0));

  p_value_after_set_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_flag_o && out_data_o[0]) |=>
      (out_valid_o && !out_flag_o));

  p_last_is_value_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o) |-> !out_flag_o);

  p_last_closes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> !out_valid_o);
endmodule

bind qt_encoder qt_encoder_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_flag_o  (out_flag_o),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o)
);

// File: tb/qt_encoder_tb_top.sv
module qt_encoder_tb_top;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, out_ready = 0;
  logic [CW-1:0] in_code = '0;
  logic in_ready, out_valid, out_flag, out_last;
  logic [CW-1:0] out_data;

  int n_tests = 0, n_fail = 0;
  int bp_mode = 0;
  bit finished = 0;
  string cur_req = "R5";
  logic [CW-1:0] tile [8][8];
  logic [CW+1:0] exp_q [$];   // {last, flag, data}

  always #5 clk = ~clk;

  qt_encoder dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sof_i(in_sof), .in_code_i(in_code),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_flag_o(out_flag), .out_data_o(out_data), .out_last_o(out_last)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int zaddr(int r, int c);
    int m = 0;
    for (int b = 0; b < 3; b++) m |= (((c >> b) & 1) << (2*b)) | (((r >> b) & 1) << (2*b+1));
    return m;
  endfunction

  task automatic build_expected();
    logic [CW-1:0] z [64];
    logic [CW+1:0] t;
    int p = 0;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) z[zaddr(r, c)] = tile[r][c];
    while (p < 64) begin
      int maxl = 0;
      bit done = 0;
      for (int l = 1; l <= 3; l++) if (p % (1 << (2*l)) == 0) maxl = l;
      for (int l = 3; l >= 1; l--) begin
        if (!done && l <= maxl) begin
          int sz = 1 << (2*l);
          bit uni = 1;
          for (int k = 0; k < sz; k++) if (z[p+k] != z[p]) uni = 0;
          if (uni) begin
            exp_q.push_back({1'b0, 1'b1, 3'd1});
            exp_q.push_back({1'b0, 1'b0, z[p]});
            p += sz;
            done = 1;
          end else exp_q.push_back({1'b0, 1'b1, 3'd0});
        end
      end
      if (!done) begin
        exp_q.push_back({1'b0, 1'b0, z[p]});
        p++;
      end
    end
    t = exp_q.pop_back();
    t[CW+1] = 1'b1;
    exp_q.push_back(t);
  endtask

  task automatic drive_px(logic [CW-1:0] code, logic sof);
    @(negedge clk);
    in_valid = 1; in_code = code; in_sof = sof;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 0; in_sof = 0;
  endtask

  task automatic send_tile();
    build_expected();
    for (int i = 0; i < 64; i++) drive_px(tile[i/8][i%8], i == 0);
    idle_in();
    #1 check(in_ready == 1'b0, "R4", in_ready, 0);
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || out_valid) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    #3;
    check(exp_q.size() == 0, cur_req, exp_q.size(), 0);
    check(in_ready == 1'b1, "R4", in_ready, 1);
  endtask

  // monitor: sets ready at negedge, samples just after
  initial begin
    logic [CW+1:0] held = '0, e;
    bit stalled = 0;
    forever begin
      @(negedge clk);
      out_ready = (bp_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      #2;
      if (stalled && out_valid)
        check({out_last, out_flag, out_data} == held, "R9", {out_last, out_flag, out_data}, held);
      stalled = 0;
      if (out_valid && !out_ready) begin
        held = {out_last, out_flag, out_data};
        stalled = 1;
      end
      if (out_valid && out_ready) begin
        if (out_flag) check(out_data[2:1] == 2'b00, "R11", out_data, {2'b00, out_data[0]});
        if (exp_q.size() == 0) check(0, cur_req, {out_flag, out_data}, -1);
        else begin
          e = exp_q.pop_front();
          check({out_flag, out_data} == e[CW:0], cur_req, {out_flag, out_data}, e[CW:0]);
          check(out_last == e[CW+1], "R10", out_last, e[CW+1]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #22;
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    @(negedge clk); rst_n = 1;

    // R5: whole tile uniform
    cur_req = "R5";
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tile[r][c] = 3'd5;
    send_tile(); drain();
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tile[r][c] = 3'd7;
    send_tile(); drain();

    // R6 R7: fully split tile
    cur_req = "R6 R7";
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tile[r][c] = CW'(r*3 + c*5 + r*c);
    send_tile(); drain();

    // R8 with backpressure: uniform 4x4 and 2x2 blocks among mixed pixels
    cur_req = "R8";
    bp_mode = 1;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tile[r][c] = CW'(r ^ (c*3));
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) tile[r][c] = 3'd6;
    for (int r = 4; r < 6; r++) for (int c = 6; c < 8; c++) tile[r][c] = 3'd1;
    for (int r = 6; r < 8; r++) for (int c = 0; c < 2; c++) tile[r][c] = 3'd0;
    send_tile(); drain();

    // R2: stray pixels before a start marker are dropped
    cur_req = "R2";
    for (int i = 0; i < 5; i++) drive_px(3'd7, 1'b0);
    idle_in();
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tile[r][c] = (r < 4) ? 3'd2 : CW'(c);
    send_tile(); drain();

    // R3: restart in mid-tile
    cur_req = "R3";
    for (int i = 0; i < 20; i++) drive_px(3'd4, i == 0);
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tile[r][c] = (c < 4) ? 3'd3 : CW'(r + c);
    send_tile(); drain();

    // R9 R10: stalls over a fully split stream
    cur_req = "R9";
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) tile[r][c] = CW'(r*7 + c);
    send_tile(); drain();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule